// File: doc/BRIEF.md
# Sample Phase Tuning Engine

This block searches for a good sampling clock phase for a card interface. A sweep starts with a one-cycle `start` pulse. For each candidate phase index, the engine drives the matching phase in degrees on `phase_out` and pulses `test_start` for one cycle. It then waits until the external transfer logic reports `test_done` together with a `test_pass` verdict.

The verdicts form contiguous windows of passing indices. After the sweep the engine makes one decision:

- If the first and last windows meet across the end of the sweep, they are joined into one window.
- If no step passed, the engine reports failure.
- If every step passed, it uses the programmable default phase.
- Otherwise it selects the centre of the longest window.

The interface has no data stream. All pins are plain control and status levels or pulses. The engine never stalls the responder: `test_done` is only looked at while a test is outstanding and is ignored at every other time.

Top module: `phase_tuner`

## Requirements
- R1: While idle or in reset, `done`, `success` and `test_start` are low and `phase_out` follows `default_phase` combinationally. Reset is synchronous and active high.
- R2: On `start` the sweep begins at index 0. The phase driven is ceil(index*360/STEPS), which is the index itself for the default of 360 steps. A passing step moves to the next index.
- R3: A failing step moves ahead by SKIP (20). If the new index would reach or pass STEPS, it is clamped to the last index (359) so that the last index is always tested. Any verdict at the last index ends the sweep, and no further `test_start` follows.
- R4: Each step produces exactly one single-cycle `test_start`. `phase_out` holds that step's phase until `test_done` arrives, and the next pulse comes only after it.
- R5: If no step passed, the engine raises `done` with `success` low, and `phase_out` shows the `default_phase` value captured at that moment.
- R6: If a single window covers index 0 through STEPS-1, the engine raises `done` and `success`, and `phase_out` shows the captured `default_phase`.
- R7: If more than one window was found and both index 0 and the last tested index passed, the last window's start replaces the first window's start and the last window is dropped. The length of such a wrapped window is counted modulo STEPS.
- R8: Window length is end-start+1, plus STEPS when that is negative. The longest window is selected; on equal lengths the earlier window is kept.
- R9: The selected index is (start + length/2) mod STEPS, using integer halving. Its phase in degrees is driven with `done` and `success` high.
- R10: `done` and the result on `phase_out` hold until the next `start`. A `start` while done begins a new sweep at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sweep (accepted when idle or done) |
| default_phase | input | 9 | Fallback phase in degrees |
| phase_out | output | 9 | Phase to the phase-shift hardware, in degrees |
| test_start | output | 1 | One-cycle request for a tuning transfer |
| test_done | input | 1 | Transfer finished (one-cycle pulse) |
| test_pass | input | 1 | Verdict, valid with `test_done` |
| done | output | 1 | Sweep decided |
| success | output | 1 | A usable phase was found |

## Verification
A behavioural model in the bench replays each pass map and predicts the exact order of tested indices, so a wrong stride, a missing clamp or an extra step shows up at the pulse where it happens. Each pass map separates one decision from the others:

- An all-fail map isolates the failure path together with the clamp to 359.
- An all-pass map isolates the default-phase fallback.
- A single interior window checks the centre arithmetic.
- Maps with windows at both ends, including single-index windows at 0 and 359, check the merge and the modulo wrap of the centre.
- Two windows of equal length check that the earlier one wins.
- A window only at the last index shows that no merge happens when index 0 failed.

A reset in mid-sweep and a change of the default input during the hold check the idle behaviour and the capture of the default phase.

// File: rtl/phase_tuner_pkg.sv
package phase_tuner_pkg;

  // Phase is always expressed in whole degrees.
  localparam int DEG_W = 9;

  typedef enum logic [2:0] {
    PT_IDLE,
    PT_ISSUE,
    PT_WAIT,
    PT_MERGE,
    PT_CHECK,
    PT_SCAN,
    PT_PICK,
    PT_DONE
  } pt_state_e;

endpackage

// File: rtl/pt_win_store.sv
// Start/end storage for passing windows: one write port, two read ports.
module pt_win_store #(
  parameter int DEPTH = 181,
  parameter int IW    = 9,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we_start,
  input  logic          we_end,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wstart,
  input  logic [IW-1:0] wend,
  input  logic [AW-1:0] raddr_a,
  output logic [IW-1:0] rstart_a,
  output logic [IW-1:0] rend_a,
  input  logic [AW-1:0] raddr_b,
  output logic [IW-1:0] rstart_b
);

  logic [IW-1:0] st_mem [DEPTH];
  logic [IW-1:0] en_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_start) st_mem[waddr] <= wstart;
    if (we_end)   en_mem[waddr] <= wend;
  end

  assign rstart_a = st_mem[raddr_a];
  assign rend_a   = en_mem[raddr_a];
  assign rstart_b = st_mem[raddr_b];

  // A write never lands outside the window table (window bookkeeping, R8)
  assert_win_addr_R8: assert property (@(posedge clk)
    (we_start || we_end) |-> (32'(waddr) < DEPTH));

endmodule

// File: rtl/pt_span.sv
// Length of a window, wrapping modulo STEPS when end lies before start.
module pt_span #(
  parameter int STEPS = 360,
  parameter int IW    = 9
) (
  input  logic [IW-1:0] s_idx,
  input  logic [IW-1:0] e_idx,
  output logic [IW-1:0] len
);

  logic signed [IW+1:0] diff;

  always_comb begin
    diff = $signed({2'b00, e_idx}) - $signed({2'b00, s_idx}) + $signed((IW+2)'(1));
    if (diff < 0) diff = diff + $signed((IW+2)'(STEPS));
    len = diff[IW-1:0];
  end

endmodule

// File: rtl/pt_phase_scale.sv
// Index to degrees: ceil(idx * 360 / STEPS).
module pt_phase_scale #(
  parameter int STEPS = 360,
  parameter int IW    = 9,
  parameter int DW    = 9
) (
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] deg
);

  assign deg = DW'((32'(idx) * 32'd360 + 32'(STEPS - 1)) / 32'(STEPS));

endmodule

// File: rtl/phase_tuner.sv
module phase_tuner
  import phase_tuner_pkg::*;
#(
  parameter int STEPS = 360,
  parameter int SKIP  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DEG_W-1:0] default_phase,
  output logic [DEG_W-1:0] phase_out,
  output logic             test_start,
  input  logic             test_done,
  input  logic             test_pass,
  output logic             done,
  output logic             success
);

  localparam int IW      = $clog2(STEPS + 1);
  localparam int MAX_WIN = STEPS / 2 + 1;
  localparam int CW      = $clog2(MAX_WIN + 1);

  localparam logic [IW-1:0] LAST_I  = IW'(STEPS - 1);
  localparam logic [IW:0]   END_W   = (IW+1)'(STEPS);
  localparam logic [IW:0]   LAST_W  = (IW+1)'(STEPS - 1);
  localparam logic [IW:0]   SKIP_W  = (IW+1)'(SKIP);

  pt_state_e        state_q;
  logic [IW-1:0]    idx_q;
  logic             prev_q, first_q;
  logic [CW-1:0]    cnt_q, scan_q;
  logic [IW-1:0]    best_len_q, best_st_q;
  logic [DEG_W-1:0] phase_q;
  logic             done_q, succ_q;

  // window store ports
  logic             we_st, we_en;
  logic [CW-1:0]    waddr;
  logic [IW-1:0]    wst, wen;
  logic [IW-1:0]    ra_st, ra_en, rb_st;
  logic [IW-1:0]    len_a;

  // step arithmetic
  logic [IW:0]      nxt_w, skip_sum;
  logic [IW:0]      mid_sum, mid_w;
  logic [IW-1:0]    sc_in;
  logic [DEG_W-1:0] sc_deg;
  logic             merge_go;

  always_comb begin
    skip_sum = {1'b0, idx_q} + SKIP_W;
    if (test_pass)               nxt_w = {1'b0, idx_q} + (IW+1)'(1);
    else if (idx_q == LAST_I)    nxt_w = END_W;
    else if (skip_sum >= END_W)  nxt_w = LAST_W;
    else                         nxt_w = skip_sum;
  end

  always_comb begin
    mid_sum = {1'b0, best_st_q} + {2'b00, best_len_q[IW-1:1]};
    mid_w   = (mid_sum >= END_W) ? (mid_sum - END_W) : mid_sum;
  end

  assign sc_in    = (state_q == PT_PICK) ? mid_w[IW-1:0] : nxt_w[IW-1:0];
  assign merge_go = (cnt_q > CW'(1)) && first_q && prev_q;

  always_comb begin
    we_st = 1'b0;
    we_en = 1'b0;
    waddr = cnt_q;
    wst   = idx_q;
    wen   = idx_q;
    if (state_q == PT_WAIT && test_done && test_pass) begin
      if (!prev_q) begin
        we_st = 1'b1;
        we_en = 1'b1;
      end else begin
        we_en = 1'b1;
        waddr = cnt_q - CW'(1);
      end
    end else if (state_q == PT_MERGE && merge_go) begin
      we_st = 1'b1;
      waddr = '0;
      wst   = rb_st;
    end
  end

  pt_win_store #(.DEPTH(MAX_WIN), .IW(IW), .AW(CW)) u_store (
    .clk      (clk),
    .we_start (we_st),
    .we_end   (we_en),
    .waddr    (waddr),
    .wstart   (wst),
    .wend     (wen),
    .raddr_a  (scan_q),
    .rstart_a (ra_st),
    .rend_a   (ra_en),
    .raddr_b  (cnt_q - CW'(1)),
    .rstart_b (rb_st)
  );

  pt_span #(.STEPS(STEPS), .IW(IW)) u_span (
    .s_idx (ra_st),
    .e_idx (ra_en),
    .len   (len_a)
  );

  pt_phase_scale #(.STEPS(STEPS), .IW(IW), .DW(DEG_W)) u_scale (
    .idx (sc_in),
    .deg (sc_deg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PT_IDLE;
      idx_q      <= '0;
      prev_q     <= 1'b0;
      first_q    <= 1'b0;
      cnt_q      <= '0;
      scan_q     <= '0;
      best_len_q <= '0;
      best_st_q  <= '0;
      phase_q    <= '0;
      done_q     <= 1'b0;
      succ_q     <= 1'b0;
    end else begin
      case (state_q)
        PT_IDLE, PT_DONE: begin
          if (start) begin
            state_q    <= PT_ISSUE;
            idx_q      <= '0;
            prev_q     <= 1'b0;
            first_q    <= 1'b0;
            cnt_q      <= '0;
            scan_q     <= '0;
            best_len_q <= '0;
            best_st_q  <= '0;
            phase_q    <= '0;
            done_q     <= 1'b0;
            succ_q     <= 1'b0;
          end
        end
        PT_ISSUE: state_q <= PT_WAIT;
        PT_WAIT: begin
          if (test_done) begin
            prev_q <= test_pass;
            if (idx_q == '0) first_q <= test_pass;
            if (test_pass && !prev_q) cnt_q <= cnt_q + CW'(1);
            idx_q <= nxt_w[IW-1:0];
            if (nxt_w >= END_W) begin
              state_q <= PT_MERGE;
            end else begin
              phase_q <= sc_deg;
              state_q <= PT_ISSUE;
            end
          end
        end
        PT_MERGE: begin
          scan_q <= '0;
          if (cnt_q == '0) begin
            done_q  <= 1'b1;
            succ_q  <= 1'b0;
            phase_q <= default_phase;
            state_q <= PT_DONE;
          end else begin
            if (merge_go) cnt_q <= cnt_q - CW'(1);
            state_q <= PT_CHECK;
          end
        end
        PT_CHECK: begin
          if (ra_st == '0 && ra_en == LAST_I) begin
            done_q  <= 1'b1;
            succ_q  <= 1'b1;
            phase_q <= default_phase;
            state_q <= PT_DONE;
          end else begin
            state_q <= PT_SCAN;
          end
        end
        PT_SCAN: begin
          if (len_a > best_len_q) begin
            best_len_q <= len_a;
            best_st_q  <= ra_st;
          end
          scan_q <= scan_q + CW'(1);
          if (scan_q == cnt_q - CW'(1)) state_q <= PT_PICK;
        end
        PT_PICK: begin
          phase_q <= sc_deg;
          done_q  <= 1'b1;
          succ_q  <= 1'b1;
          state_q <= PT_DONE;
        end
        default: state_q <= PT_IDLE;
      endcase
    end
  end

  assign phase_out  = (state_q == PT_IDLE) ? default_phase : phase_q;
  assign test_start = (state_q == PT_ISSUE);
  assign done       = done_q;
  assign success    = succ_q;

  // ---------------- assertions ----------------
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == PT_IDLE) |-> (!done && !success && !test_start));

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
    test_start |-> (idx_q < END_W[IW-1:0] || idx_q == LAST_I));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    test_start |=> !test_start);

  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == PT_WAIT && !test_done) |=> $stable(phase_out));

  assert_success_done_R5: assert property (@(posedge clk) disable iff (rst)
    success |-> done);

  assert_win_cap_R8: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) <= MAX_WIN);

  assert_best_grows_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == PT_SCAN) |=> (best_len_q >= $past(best_len_q)));

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(phase_out)));

endmodule

// File: tb/phase_tuner_tb.sv
module phase_tuner_tb;

  localparam int STEPS = 360;
  localparam int SKIP  = 20;

  logic       clk = 1'b0;
  logic       rst, start, test_done, test_pass;
  logic [8:0] default_phase;
  logic [8:0] phase_out;
  logic       test_start, done, success;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;   // 50 MHz

  phase_tuner #(.STEPS(STEPS), .SKIP(SKIP)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .default_phase (default_phase),
    .phase_out     (phase_out),
    .test_start    (test_start),
    .test_done     (test_done),
    .test_pass     (test_pass),
    .done          (done),
    .success       (success)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int deg(input int i);
    return (i * 360 + STEPS - 1) / STEPS;
  endfunction

  // Behavioural reference: tested index order and final result.
  task automatic model(input logic [359:0] pm, input int dflt,
                       ref int q[$], output bit ok, output int ph);
    int st[$];
    int en[$];
    int i = 0;
    bit prev = 0, first = 0, v = 0;
    int best = -1, bl = -1;
    while (i < STEPS) begin
      q.push_back(i);
      v = pm[i];
      if (i == 0) first = v;
      if (!prev && v) begin st.push_back(i); en.push_back(i); end
      else if (v) en[en.size()-1] = i;
      if (v) i++;
      else if (i == STEPS - 1) i++;
      else begin i += SKIP; if (i >= STEPS) i = STEPS - 1; end
      prev = v;
    end
    if (st.size() == 0) begin ok = 0; ph = dflt; return; end
    if (st.size() > 1 && first && v) begin
      st[0] = st[st.size()-1];
      void'(st.pop_back());
      void'(en.pop_back());
    end
    ok = 1;
    if (st[0] == 0 && en[0] == STEPS - 1) begin ph = dflt; return; end
    foreach (st[k]) begin
      int len = en[k] - st[k] + 1;
      if (len < 0) len += STEPS;
      if (len > bl) begin bl = len; best = k; end
    end
    ph = deg((st[best] + bl / 2) % STEPS);
  endtask

  task automatic run_case(input logic [359:0] pm, input int dflt, input string tag);
    int q[$];
    bit eok;
    int eph;
    int w;
    bit extra = 0;
    model(pm, dflt, q, eok, eph);
    default_phase = dflt[8:0];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    foreach (q[k]) begin
      w = 0;
      while (!test_start && w < 50) begin @(negedge clk); w++; end
      if (!test_start) begin
        chk(0, "R2 step not issued", 0, q[k]);
        return;
      end
      chk(phase_out == 9'(deg(q[k])), "R2/R3 tested index", int'(phase_out), deg(q[k]));
      for (int j = 0; j < 1 + k % 3; j++) begin
        @(negedge clk);
        chk(!test_start && phase_out == 9'(deg(q[k])), "R4 hold while waiting",
            int'(phase_out), deg(q[k]));
      end
      test_done = 1'b1;
      test_pass = pm[q[k]];
      @(negedge clk);
      test_done = 1'b0;
      test_pass = 1'b0;
    end
    w = 0;
    while (!done && w < 1000) begin
      if (test_start) extra = 1;
      @(negedge clk);
      w++;
    end
    chk(!extra, "R3 no step after last index", int'(extra), 0);
    chk(done, "R10 done raised", int'(done), 1);
    chk(success == eok, {tag, " outcome"}, int'(success), int'(eok));
    chk(phase_out == 9'(eph), {tag, " phase"}, int'(phase_out), eph);
    default_phase = 9'(dflt + 1);   // result must not follow the input now
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(done && phase_out == 9'(eph), "R10 result held", int'(phase_out), eph);
    end
  endtask

  initial begin
    logic [359:0] pm;
    rst = 1'b1; start = 1'b0; test_done = 1'b0; test_pass = 1'b0;
    default_phase = 9'd12;
    repeat (3) @(negedge clk);
    chk(!done && !success && !test_start, "R1 reset outputs", int'(done), 0);
    chk(phase_out == 9'd12, "R1 reset phase", int'(phase_out), 12);
    rst = 1'b0;
    @(negedge clk);
    default_phase = 9'd200;
    #1;
    chk(phase_out == 9'd200, "R1 idle follows default", int'(phase_out), 200);

    pm = '0;
    run_case(pm, 45, "R5 all fail");

    pm = '1;
    run_case(pm, 77, "R6 all pass");

    pm = '0;
    for (int i = 100; i <= 150; i++) pm[i] = 1'b1;
    run_case(pm, 5, "R9 interior centre");

    pm = '0;
    for (int i = 0; i <= 30; i++) pm[i] = 1'b1;
    for (int i = 150; i <= 170; i++) pm[i] = 1'b1;
    for (int i = 300; i <= 359; i++) pm[i] = 1'b1;
    run_case(pm, 5, "R7 wrap merge");

    pm = '0;
    for (int i = 40; i <= 59; i++) pm[i] = 1'b1;
    for (int i = 200; i <= 219; i++) pm[i] = 1'b1;
    run_case(pm, 5, "R8 tie earlier");

    pm = '0;
    pm[359] = 1'b1;
    run_case(pm, 5, "R7 last only");

    pm = '0;
    pm[0] = 1'b1;
    pm[359] = 1'b1;
    run_case(pm, 5, "R9 wrap modulo");

    // reset in mid-sweep
    default_phase = 9'd30;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    test_done = 1'b1; test_pass = 1'b1;
    @(negedge clk);
    test_done = 1'b0; test_pass = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!done && !test_start, "R1 reset mid sweep", int'(done), 0);
    chk(phase_out == 9'd30, "R1 reset mid sweep phase", int'(phase_out), 30);
    rst = 1'b0;
    @(negedge clk);
    default_phase = 9'd301;
    #1;
    chk(phase_out == 9'd301, "R1 idle follows new default", int'(phase_out), 301);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule